// File: doc/BRIEF.md
# Bus Error Cause Register

This block sits on a 32-bit processor bus and turns two kinds of forbidden access into a bus error. The first kind is any read or write to a reserved probe word. The second is a read of the word where a floating-point accelerator would be if one were fitted. When either occurs, the block does three things. It sends a registered, single-cycle bus error strobe to the CPU. It returns all ones for a read. It records a cause bit in a 32-bit status register.

Software reads that register to learn why the last bus errors happened. The read clears the register. Software can also write the register one byte lane at a time. Cause bits pile up by OR until software reads them.

Cause bits are set through a one-cycle pending stage. A status access in the cycle right after a trigger therefore sees the register as it was before that trigger. The trigger's cause bit is not lost to that access, whether it clears or writes the register.

Top module: `berr_status_unit`

## Requirements
- R1: After a synchronous active-low reset, the status register reads zero and `berr_o` and `rsp_valid` are low. This holds even if a cause was recorded before the reset.
- R2: A read or a write to the probe word (default 0x4000_0000) sets status bit 29. The bit can be read from the second cycle after the access onward.
- R3: A read of the accelerator word (default 0x5C00_0F14) sets status bit 26. A write to that word raises no strobe, returns nothing and leaves the status register unchanged.
- R4: Every triggering access raises `berr_o` in the cycle after the access, for exactly one cycle.
- R5: A triggering read returns `rsp_valid` high with `rsp_rdata` = 0xFFFF_FFFF in the cycle after the access. A triggering write gives no `rsp_valid`.
- R6: A read of the status word (default 0x6100_0400) returns the register's value in the cycle after the access and leaves the register at zero.
- R7: A write to the status word replaces byte i (bits 8i+7..8i) with the write data only where `req_be[i]` is 1. The other bytes keep their value.
- R8: Cause bits accumulate by OR. A bit already set stays set through later triggers until the register is read or overwritten.
- R9: A status read or write in the cycle right after a trigger works on the value before that trigger. The read returns that value and the write merges into it. The trigger's cause bit is still present afterwards.
- R10: An access to any other address gives no strobe and no response, and leaves the status register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A bus access is presented this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 32 | Byte address of the access |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte-lane enables for writes; bit i covers data bits 8i+7..8i |
| berr_o | output | 1 | One-cycle bus error strobe to the CPU |
| rsp_valid | output | 1 | Read data is valid this cycle |
| rsp_rdata | output | 32 | Read data |

## Verification
Two updates to the status register can land on the same clock edge. One is the deferred setting of a cause bit from a trigger. The other is software's read-clear or byte-lane write. The bench provokes this by issuing a probe access and, in the very next cycle, a status read or a masked status write. It then judges the result in two steps. The status access must have returned or merged the value from before the trigger. A further status read must show the trigger's bit together with any merged bytes.

// File: rtl/berr_pkg.sv
// Package berr_pkg
// Holds the types shared by the bus error cause register modules.
// Assumes at most one address window is hit per cycle.
package berr_pkg;

    // One flag for each kind of decoded access in the current cycle.
    typedef struct packed {
        logic probe;     // any access to the probe word
        logic probe_rd;  // read of the probe word
        logic fpa_rd;    // read of the absent accelerator word
        logic stat_rd;   // read of the status word
        logic stat_wr;   // write of the status word
    } berr_hit_t;

endpackage

// File: rtl/berr_decode.sv
// Module berr_decode
// Compares the access address, word aligned, against the three windows
// and flags what kind of access is on the bus this cycle.
// Assumes the three window addresses are distinct words. Purely combinational.
module berr_decode
    import berr_pkg::*;
#(
    parameter int          ADDR_W      = 32,
    parameter logic [31:0] PROBE_ADDR  = 32'h4000_0000,
    parameter logic [31:0] FPA_ADDR    = 32'h5C00_0F14,
    parameter logic [31:0] STATUS_ADDR = 32'h6100_0400
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output berr_hit_t         hit_o
);
    localparam int WORD_LSB = 2;

    logic at_probe, at_fpa, at_status;

    // Word compare of the incoming address against each window.
    always_comb begin
        at_probe  = req_addr[ADDR_W-1:WORD_LSB] == PROBE_ADDR[ADDR_W-1:WORD_LSB];
        at_fpa    = req_addr[ADDR_W-1:WORD_LSB] == FPA_ADDR[ADDR_W-1:WORD_LSB];
        at_status = req_addr[ADDR_W-1:WORD_LSB] == STATUS_ADDR[ADDR_W-1:WORD_LSB];
    end

    // Qualify the matches with the valid strobe and the direction.
    always_comb begin
        hit_o.probe    = req_valid && at_probe;
        hit_o.probe_rd = req_valid && at_probe && !req_write;
        hit_o.fpa_rd   = req_valid && at_fpa && !req_write;
        hit_o.stat_rd  = req_valid && at_status && !req_write;
        hit_o.stat_wr  = req_valid && at_status && req_write;
    end
endmodule

// File: rtl/berr_cause_reg.sv
// Module berr_cause_reg
// The status register. A trigger registers its cause bits into a pending
// vector. On the next edge they are ORed into the register, after any
// read-clear or byte-lane write of that same edge, so a new cause always
// survives a simultaneous clear.
// Assumes DATA_W is a multiple of 8 and the cause bit positions lie within it.
module berr_cause_reg
    import berr_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int PROBE_BIT = 29,
    parameter int FPA_BIT   = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  berr_hit_t         hit_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W/8-1:0] be_i,
    output logic [DATA_W-1:0] status_o
);
    localparam int NLANE = DATA_W / 8;

    logic [DATA_W-1:0] status_q;
    logic [DATA_W-1:0] pend_q;
    logic [DATA_W-1:0] set_vec;
    logic [DATA_W-1:0] merged;
    logic [DATA_W-1:0] base;

    // Cause bits requested by this cycle's access.
    always_comb begin
        set_vec = '0;
        set_vec[PROBE_BIT] = hit_i.probe;
        set_vec[FPA_BIT]   = hit_i.fpa_rd;
    end

    // Byte-lane merge of write data into the held value.
    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        assign merged[8*g +: 8] = be_i[g] ? wdata_i[8*g +: 8] : status_q[8*g +: 8];
    end

    // Software's effect on the register before the pending causes are added.
    always_comb begin
        if (hit_i.stat_rd)
            base = '0;
        else if (hit_i.stat_wr)
            base = merged;
        else
            base = status_q;
    end

    // Pending stage: hold one cycle of new causes.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= set_vec;
    end

    // Register update: software effect, then OR in pending causes.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= base | pend_q;
    end

    assign status_o = status_q;

    AST_PEND_SURVIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q != '0) |=> ((status_q & $past(pend_q)) == $past(pend_q))); // R9
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_i.stat_rd && pend_q == '0) |=> (status_q == '0)); // R6
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_i.stat_rd && !hit_i.stat_wr && pend_q == '0) |=> $stable(status_q)); // R8
endmodule

// File: rtl/berr_resp.sv
// Module berr_resp
// Produces the registered bus error strobe and the read response. A
// triggering read returns all ones. A status read returns the register as
// it stood before this edge. Other reads get no response.
// Assumes at most one window is hit per cycle.
module berr_resp
    import berr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  berr_hit_t         hit_i,
    input  logic [DATA_W-1:0] status_i,
    output logic              berr_o,
    output logic              rvalid_o,
    output logic [DATA_W-1:0] rdata_o
);
    logic              berr_q;
    logic              rvalid_q;
    logic [DATA_W-1:0] rdata_q;
    logic              trig;
    logic              trig_rd;

    // Classify the access for the response.
    always_comb begin
        trig    = hit_i.probe || hit_i.fpa_rd;
        trig_rd = hit_i.probe_rd || hit_i.fpa_rd;
    end

    // One-cycle strobe for each triggering access.
    always_ff @(posedge clk) begin
        if (!rst_n) berr_q <= 1'b0;
        else        berr_q <= trig;
    end

    // Read response: all ones on a trigger, the register on a status read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid_q <= 1'b0;
            rdata_q  <= '0;
        end else begin
            rvalid_q <= trig_rd || hit_i.stat_rd;
            if (trig_rd)
                rdata_q <= '1;
            else if (hit_i.stat_rd)
                rdata_q <= status_i;
            else
                rdata_q <= '0;
        end
    end

    assign berr_o   = berr_q;
    assign rvalid_o = rvalid_q;
    assign rdata_o  = rdata_q;

    AST_BERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        berr_q |-> $past(hit_i.probe || hit_i.fpa_rd)); // R4
    AST_TRIG_READ_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (berr_q && rvalid_q) |-> (rdata_q == '1)); // R5
endmodule

// File: rtl/berr_status_unit.sv
// Module berr_status_unit
// Top of the bus error cause register. It joins the address decode, the
// status register and the response stage.
// Assumes a single-cycle bus where every access is presented for one cycle
// with req_valid high.
module berr_status_unit
    import berr_pkg::*;
#(
    parameter int          ADDR_W      = 32,
    parameter int          DATA_W      = 32,
    parameter logic [31:0] PROBE_ADDR  = 32'h4000_0000,
    parameter logic [31:0] FPA_ADDR    = 32'h5C00_0F14,
    parameter logic [31:0] STATUS_ADDR = 32'h6100_0400,
    parameter int          PROBE_BIT   = 29,
    parameter int          FPA_BIT     = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W/8-1:0] req_be,
    output logic              berr_o,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);
    berr_hit_t         hit;
    logic [DATA_W-1:0] status;

    berr_decode #(
        .ADDR_W(ADDR_W), .PROBE_ADDR(PROBE_ADDR),
        .FPA_ADDR(FPA_ADDR), .STATUS_ADDR(STATUS_ADDR)
    ) u_decode (
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .hit_o(hit)
    );

    berr_cause_reg #(
        .DATA_W(DATA_W), .PROBE_BIT(PROBE_BIT), .FPA_BIT(FPA_BIT)
    ) u_cause (
        .clk(clk), .rst_n(rst_n), .hit_i(hit),
        .wdata_i(req_wdata), .be_i(req_be), .status_o(status)
    );

    berr_resp #(.DATA_W(DATA_W)) u_resp (
        .clk(clk), .rst_n(rst_n), .hit_i(hit), .status_i(status),
        .berr_o(berr_o), .rvalid_o(rsp_valid), .rdata_o(rsp_rdata)
    );
endmodule

// File: tb/berr_status_unit_tb.sv
module berr_status_unit_tb;
    localparam logic [31:0] A_PROBE = 32'h4000_0000;
    localparam logic [31:0] A_FPA   = 32'h5C00_0F14;
    localparam logic [31:0] A_STAT  = 32'h6100_0400;
    localparam logic [31:0] A_OTHER = 32'h6100_0800;
    localparam logic [31:0] ONES    = 32'hFFFF_FFFF;

    typedef struct packed {
        logic        wr;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic [3:0]  be;
        logic        e_berr;
        logic        e_rv;
        logic [31:0] e_rdata;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{1'b0, A_STAT,  32'h0,          4'h0, 1'b0, 1'b1, 32'h0,          8'd6},  // R6 empty after reset
        '{1'b1, A_STAT,  32'h1234_5678,  4'h5, 1'b0, 1'b0, 32'h0,          8'd7},  // R7 lanes 0 and 2
        '{1'b0, A_STAT,  32'h0,          4'h0, 1'b0, 1'b1, 32'h0034_0078,  8'd7},  // R7 merged value
        '{1'b0, A_STAT,  32'h0,          4'h0, 1'b0, 1'b1, 32'h0,          8'd6},  // R6 cleared
        '{1'b0, A_PROBE, 32'h0,          4'h0, 1'b1, 1'b1, ONES,           8'd5},  // R5 probe read
        '{1'b0, A_STAT,  32'h0,          4'h0, 1'b0, 1'b1, 32'h2000_0000,  8'd2},  // R2 bit 29
        '{1'b1, A_PROBE, 32'h0,          4'hF, 1'b1, 1'b0, 32'h0,          8'd2},  // R2 probe write
        '{1'b0, A_FPA,   32'h0,          4'h0, 1'b1, 1'b1, ONES,           8'd3},  // R3 accel read
        '{1'b0, A_STAT,  32'h0,          4'h0, 1'b0, 1'b1, 32'h2400_0000,  8'd8},  // R8 both causes
        '{1'b1, A_FPA,   32'hDEAD_BEEF,  4'hF, 1'b0, 1'b0, 32'h0,          8'd3},  // R3 accel write ignored
        '{1'b0, A_OTHER, 32'h0,          4'h0, 1'b0, 1'b0, 32'h0,          8'd10}, // R10 other read
        '{1'b1, A_OTHER, 32'hFFFF_FFFF,  4'hF, 1'b0, 1'b0, 32'h0,          8'd10}, // R10 other write
        '{1'b0, A_STAT,  32'h0,          4'h0, 1'b0, 1'b1, 32'h0,          8'd10}, // R10 R3 still empty
        '{1'b1, A_STAT,  32'hFFFF_FFFF,  4'h8, 1'b0, 1'b0, 32'h0,          8'd7},  // R7 top lane
        '{1'b0, A_PROBE, 32'h0,          4'h0, 1'b1, 1'b1, ONES,           8'd4},  // R4 strobe
        '{1'b0, A_STAT,  32'h0,          4'h0, 1'b0, 1'b1, 32'hFF00_0000,  8'd8},  // R8 OR into set bits
        '{1'b0, A_STAT,  32'h0,          4'h0, 1'b0, 1'b1, 32'h0,          8'd6}   // R6 cleared
    };

    logic        clk;
    logic        rst_n;
    logic        req_valid;
    logic        req_write;
    logic [31:0] req_addr;
    logic [31:0] req_wdata;
    logic [3:0]  req_be;
    logic        berr_o;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    bit done     = 0;

    berr_status_unit u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .berr_o(berr_o), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    // One access for one cycle, entered and left at a falling edge.
    task automatic access(input logic wr, input logic [31:0] a,
                          input logic [31:0] d, input logic [3:0] be);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0; req_be = '0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            finish_run();
        end
    end

    initial begin
        req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0; req_be = '0;
        rst_n = 0;
        @(negedge clk);
        do_reset();

        // R1 reset state
        check("R1", "berr after reset", {31'b0, berr_o}, 32'h0);
        check("R1", "rsp_valid after reset", {31'b0, rsp_valid}, 32'h0);

        // Table walk: each access followed by one idle cycle
        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d", VECS[i].req);
            access(VECS[i].wr, VECS[i].addr, VECS[i].wdata, VECS[i].be);
            check(tag, $sformatf("vec %0d berr", i), {31'b0, berr_o}, {31'b0, VECS[i].e_berr});
            check(tag, $sformatf("vec %0d rsp_valid", i), {31'b0, rsp_valid}, {31'b0, VECS[i].e_rv});
            if (VECS[i].e_rv)
                check(tag, $sformatf("vec %0d rdata", i), rsp_rdata, VECS[i].e_rdata);
            idle();
            check("R4", $sformatf("vec %0d strobe one cycle", i), {31'b0, berr_o}, 32'h0);
        end

        // R9: status read right after a probe sees the old value, bit survives
        access(1'b0, A_PROBE, '0, '0);
        check("R4", "b2b strobe", {31'b0, berr_o}, 32'h1);
        access(1'b0, A_STAT, '0, '0);
        check("R4", "b2b strobe dropped", {31'b0, berr_o}, 32'h0);
        check("R9", "b2b read returns pre-trigger value", rsp_rdata, 32'h0);
        idle();
        access(1'b0, A_STAT, '0, '0);
        check("R9", "bit survives read-clear", rsp_rdata, 32'h2000_0000);
        idle();

        // R9: masked write right after a probe merges, bit survives
        access(1'b0, A_PROBE, '0, '0);
        access(1'b1, A_STAT, 32'h5555_55AB, 4'h1);
        idle();
        access(1'b0, A_STAT, '0, '0);
        check("R9", "bit survives masked write", rsp_rdata, 32'h2000_00AB);
        idle();

        // R1: reset clears a recorded cause
        access(1'b0, A_FPA, '0, '0);
        idle();
        do_reset();
        check("R1", "berr low after mid-run reset", {31'b0, berr_o}, 32'h0);
        access(1'b0, A_STAT, '0, '0);
        check("R1", "status zero after reset", rsp_rdata, 32'h0);
        idle();

        done = 1;
        finish_run();
    end
endmodule